// File: doc/BRIEF.md
# Two-wire serial memory slave controller

This block is the bus-side protocol engine of a byte-addressed serial memory slave on a two-wire I2C-style bus. A fast system clock samples SCL and SDA through synchronizers. The block finds start and stop conditions and decodes the 8-bit device word. After a write header it takes a two-byte memory address and acknowledges every byte. During a read it shifts data out MSB first. The block drives SDA only through an open-drain enable: when that enable is high, the pad pulls the line low.

The block keeps a 17-bit current-address pointer. The top bit of that pointer comes from the device word of a write header. The pointer moves in two different ways. During a read it advances across the whole 128K array and wraps to zero. After a write it advances only within the current page.

Read data comes from a synchronous byte memory, with data valid one clock after the request. The block hands each written byte, with its address, to a separate page-write unit. It sends that unit a commit strobe at the stop. The unit returns a busy flag, and the block does not acknowledge the device word while that flag is set. This lets a master poll for the end of the internal write cycle.

Top module: `tw_mem_slave`

## Requirements
- R1: The device word is taken MSB first as code bits 1,0,1,0, then the A2 and A1 select bits (which must equal `pin_sel_i[1]` and `pin_sel_i[0]`), then address bit 16, then R/W (1 = read, 0 = write). On a match the slave pulls SDA low for the ninth clock. On any mismatch it leaves SDA released, ignores every later bit, and acknowledges nothing until the next start.
- R2: In a write, the slave acknowledges each of the following with a low ninth bit: the device word, the high address byte (bits 15..8), the low address byte (bits 7..0), and every data byte.
- R3: Each data byte is presented on `wr_en_o` together with the current pointer. The pointer then steps in its low `PAGE_W` bits only (8 by default), so it wraps to the first byte of the same page.
- R4: Read data goes out MSB first. The slave changes SDA only while SCL is low, after a falling edge. A start or stop may release SDA at any time.
- R5: Each byte sent in a read is fetched from the pointer address. The pointer then steps by one across all 17 bits and wraps from 0x1FFFF to 0x00000, and reading continues past the wrap.
- R6: After a read byte the slave releases SDA and samples the ninth bit. Low sends the byte at the next address. High makes the slave keep SDA released and fetch nothing more until a start or stop.
- R7: A current-address read starts at the last accessed address plus one. The address bit in the read device word has no effect.
- R8: A write header of only the device word and two address bytes, then a repeated start and a read device word, reads from the address just loaded.
- R9: While `busy_i` is high, a device word receives no acknowledge. Once `busy_i` is low the same word is acknowledged.
- R10: A stop after at least one data byte gives a one-cycle `wr_commit_o` pulse. A stop or start in mid-byte aborts the transfer. A stop without data bytes, or a start, gives no commit.
- R11: After reset SDA is released, no strobe is active, and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| pin_sel_i | input | 2 | Strapped select bits, [1] = A2, [0] = A1 |
| busy_i | input | 1 | Page-write unit is in its internal write cycle |
| mem_rdata_i | input | 8 | Read data, valid the clock after a request |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| mem_rd_o | output | 1 | One-cycle read request |
| mem_addr_o | output | 17 | Read address |
| wr_en_o | output | 1 | One-cycle strobe for a received data byte |
| wr_addr_o | output | 17 | Address of the data byte |
| wr_data_o | output | 8 | Data byte |
| wr_commit_o | output | 1 | One-cycle pulse: start the internal write cycle |

## Verification
The bench builds the block with its default parameters: a 256-byte page and two synchronizer stages. With these values, a page write starting two bytes below a page boundary exercises the in-page wrap. A random read at 0x1FFFE exercises the full-array wrap in only three bytes. The bench holds SCL in each quarter-bit phase for ten system clocks, which is enough for the synchronizer delay and the one-cycle memory latency. Busy polling, aborts, mismatched words and the post-NACK hold are all reached with these same settings.

// File: rtl/tw_pkg.sv
package tw_pkg;
    localparam int ADDR_W = 17;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_RACK,
        ST_HOLD
    } tw_state_e;

    typedef enum logic [1:0] {
        K_DEV,
        K_AHI,
        K_ALO,
        K_DATA
    } tw_kind_e;
endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[DEPTH-2:0], line_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  = chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall_o  = ~chain_q[STAGES-1] & chain_q[STAGES];
endmodule

// File: rtl/tw_addr_ptr.sv
module tw_addr_ptr #(
    parameter int AW     = 17,
    parameter int PAGE_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] load_val_i,
    input  logic          step_full_i,
    input  logic          step_page_i,
    output logic [AW-1:0] ptr_o
);
    localparam int HI_W = AW - PAGE_W;

    logic [AW-1:0]     ptr_d, ptr_q;
    logic [PAGE_W-1:0] lo_inc;

    always_comb begin
        lo_inc = ptr_q[PAGE_W-1:0] + 1'b1;
        ptr_d  = ptr_q;
        if (load_i)           ptr_d = load_val_i;
        else if (step_full_i) ptr_d = ptr_q + 1'b1;
        else if (step_page_i) ptr_d = {ptr_q[AW-1:AW-HI_W], lo_inc};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr_o = ptr_q;
endmodule

// File: rtl/tw_mem_slave.sv
module tw_mem_slave #(
    parameter int         PAGE_W      = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] DEV_CODE    = 4'b1010
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      scl_i,
    input  logic                      sda_i,
    input  logic [1:0]                pin_sel_i,
    input  logic                      busy_i,
    input  logic [tw_pkg::BYTE_W-1:0] mem_rdata_i,
    output logic                      sda_oe_o,
    output logic                      mem_rd_o,
    output logic [tw_pkg::ADDR_W-1:0] mem_addr_o,
    output logic                      wr_en_o,
    output logic [tw_pkg::ADDR_W-1:0] wr_addr_o,
    output logic [tw_pkg::BYTE_W-1:0] wr_data_o,
    output logic                      wr_commit_o
);
    import tw_pkg::*;

    localparam int NLINES = 2;
    localparam int BW     = BYTE_W;
    localparam int AW     = ADDR_W;
    localparam logic [2:0] LAST_BIT = 3'(BW - 1);

    typedef struct packed {
        tw_state_e st;
        tw_kind_e  kind;
        logic [2:0]    bitcnt;
        logic          got;
        logic [BW-1:0] sh;
        logic [BW-1:0] txbuf;
        logic          rw;
        logic          a16;
        logic [BW-1:0] ahi;
        logic          wrote;
        logic          oe;
        logic          rd;
        logic          pend;
        logic          wr;
        logic [AW-1:0] xaddr;
        logic [BW-1:0] wdata;
        logic          commit;
    } tw_regs_t;

    // line synchronizers: index 0 = SCL, index 1 = SDA
    logic [NLINES-1:0] line_raw, line_lvl, line_rise, line_fall;
    assign line_raw = {sda_i, scl_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_sync
        tw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (line_raw[g]),
            .level_o(line_lvl[g]),
            .rise_o (line_rise[g]),
            .fall_o (line_fall[g])
        );
    end

    logic scl_s, scl_rise, scl_fall, sda_s;
    logic start_evt, stop_evt;
    assign scl_s     = line_lvl[0];
    assign scl_rise  = line_rise[0];
    assign scl_fall  = line_fall[0];
    assign sda_s     = line_lvl[1];
    assign start_evt = line_fall[1] & scl_s;
    assign stop_evt  = line_rise[1] & scl_s;

    tw_regs_t r_d, r_q;

    logic          ptr_load, ptr_full, ptr_page;
    logic [AW-1:0] ptr_val, ptr;

    tw_addr_ptr #(.AW(AW), .PAGE_W(PAGE_W)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (ptr_load),
        .load_val_i (ptr_val),
        .step_full_i(ptr_full),
        .step_page_i(ptr_page),
        .ptr_o      (ptr)
    );

    logic dev_match;
    assign dev_match = (r_q.sh[7:4] == DEV_CODE) && (r_q.sh[3:2] == pin_sel_i);

    always_comb begin
        r_d        = r_q;
        r_d.rd     = 1'b0;
        r_d.wr     = 1'b0;
        r_d.commit = 1'b0;
        r_d.pend   = r_q.rd;
        ptr_load   = 1'b0;
        ptr_full   = 1'b0;
        ptr_page   = 1'b0;
        ptr_val    = {r_q.a16, r_q.ahi, r_q.sh};

        if (r_q.pend) r_d.txbuf = mem_rdata_i;

        if (stop_evt) begin
            r_d.st     = ST_IDLE;
            r_d.oe     = 1'b0;
            r_d.commit = r_q.wrote;
            r_d.wrote  = 1'b0;
        end else if (start_evt) begin
            r_d.st     = ST_RX;
            r_d.kind   = K_DEV;
            r_d.bitcnt = '0;
            r_d.got    = 1'b0;
            r_d.oe     = 1'b0;
            r_d.wrote  = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_IDLE: begin
                end
                ST_RX: begin
                    if (scl_rise) begin
                        r_d.sh     = {r_q.sh[BW-2:0], sda_s};
                        r_d.bitcnt = r_q.bitcnt + 3'd1;
                        if (r_q.bitcnt == LAST_BIT) r_d.got = 1'b1;
                    end else if (scl_fall && r_q.got) begin
                        r_d.got    = 1'b0;
                        r_d.bitcnt = '0;
                        unique case (r_q.kind)
                            K_DEV: begin
                                if (dev_match && !busy_i) begin
                                    r_d.st  = ST_ACK;
                                    r_d.oe  = 1'b1;
                                    r_d.rw  = r_q.sh[0];
                                    if (r_q.sh[0]) begin
                                        r_d.rd    = 1'b1;
                                        r_d.xaddr = ptr;
                                        ptr_full  = 1'b1;
                                    end else begin
                                        r_d.a16 = r_q.sh[1];
                                    end
                                end else begin
                                    r_d.st = ST_IDLE;
                                end
                            end
                            K_AHI: begin
                                r_d.ahi = r_q.sh;
                                r_d.st  = ST_ACK;
                                r_d.oe  = 1'b1;
                            end
                            K_ALO: begin
                                ptr_load = 1'b1;
                                r_d.st   = ST_ACK;
                                r_d.oe   = 1'b1;
                            end
                            K_DATA: begin
                                r_d.wr    = 1'b1;
                                r_d.xaddr = ptr;
                                r_d.wdata = r_q.sh;
                                r_d.wrote = 1'b1;
                                ptr_page  = 1'b1;
                                r_d.st    = ST_ACK;
                                r_d.oe    = 1'b1;
                            end
                            default: r_d.st = ST_IDLE;
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        r_d.oe = 1'b0;
                        if (r_q.kind == K_DEV && r_q.rw) begin
                            r_d.st     = ST_TX;
                            r_d.sh     = r_q.txbuf;
                            r_d.oe     = ~r_q.txbuf[BW-1];
                            r_d.bitcnt = '0;
                        end else begin
                            r_d.st = ST_RX;
                            unique case (r_q.kind)
                                K_DEV:   r_d.kind = K_AHI;
                                K_AHI:   r_d.kind = K_ALO;
                                default: r_d.kind = K_DATA;
                            endcase
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (r_q.bitcnt == LAST_BIT) begin
                            r_d.oe  = 1'b0;
                            r_d.st  = ST_RACK;
                            r_d.got = 1'b0;
                        end else begin
                            r_d.sh     = {r_q.sh[BW-2:0], 1'b0};
                            r_d.oe     = ~r_q.sh[BW-2];
                            r_d.bitcnt = r_q.bitcnt + 3'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        if (!sda_s) begin
                            r_d.got   = 1'b1;
                            r_d.rd    = 1'b1;
                            r_d.xaddr = ptr;
                            ptr_full  = 1'b1;
                        end else begin
                            r_d.st = ST_HOLD;
                        end
                    end else if (scl_fall && r_q.got) begin
                        r_d.got    = 1'b0;
                        r_d.st     = ST_TX;
                        r_d.sh     = r_q.txbuf;
                        r_d.oe     = ~r_q.txbuf[BW-1];
                        r_d.bitcnt = '0;
                    end
                end
                ST_HOLD: begin
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.kind  <= K_DEV;
        end else begin
            r_q <= r_d;
        end
    end

    tw_state_e st_q;
    assign st_q = r_q.st;

    assign sda_oe_o    = r_q.oe;
    assign mem_rd_o    = r_q.rd;
    assign mem_addr_o  = r_q.xaddr;
    assign wr_en_o     = r_q.wr;
    assign wr_addr_o   = r_q.xaddr;
    assign wr_data_o   = r_q.wdata;
    assign wr_commit_o = r_q.commit;
endmodule

// File: rtl/tw_mem_slave_chk.sv
module tw_mem_slave_chk (
    input logic              clk,
    input logic              rst_n,
    input logic              sda_oe,
    input logic              scl_lvl,
    input logic              start_evt,
    input logic              stop_evt,
    input tw_pkg::tw_state_e st,
    input logic              mem_rd,
    input logic              wr_en,
    input logic              wr_commit
);
    import tw_pkg::*;

    AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe) && !$past(start_evt) && !$past(stop_evt)) |-> !$past(scl_lvl)) // R4
        else $error("sda enable changed while SCL high");

    AST_COMMIT_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> $past(stop_evt)) // R10
        else $error("commit without stop");

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, wr_en, wr_commit})) // R3
        else $error("overlapping strobes");

    AST_DRIVE_IN_ACK_OR_TX: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> (st == ST_ACK || st == ST_TX)) // R2
        else $error("sda driven outside ack or data phase");

    AST_STANDBY_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE || st == ST_HOLD) |-> !sda_oe) // R6
        else $error("sda driven in standby or hold");
endmodule

bind tw_mem_slave tw_mem_slave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_oe   (sda_oe_o),
    .scl_lvl  (scl_s),
    .start_evt(start_evt),
    .stop_evt (stop_evt),
    .st       (st_q),
    .mem_rd   (mem_rd_o),
    .wr_en    (wr_en_o),
    .wr_commit(wr_commit_o)
);

// File: tb/sim_tw_mem_slave.sv
`timescale 1ns/1ps
module sim_tw_mem_slave;
    localparam int Q = 10;
    localparam int BUSY_CYC = 2000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [1:0] pin_sel = 2'b10;
    logic busy = 1'b0;
    logic [7:0] mem_rdata = '0;
    logic sda_oe, mem_rd, wr_en, wr_commit;
    logic [16:0] mem_addr, wr_addr;
    logic [7:0] wr_data;
    logic sda_line;

    always #2 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    tw_mem_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .pin_sel_i(pin_sel), .busy_i(busy), .mem_rdata_i(mem_rdata),
        .sda_oe_o(sda_oe), .mem_rd_o(mem_rd), .mem_addr_o(mem_addr),
        .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .wr_commit_o(wr_commit)
    );

    function automatic logic [7:0] pat(input logic [16:0] a);
        return a[7:0] ^ a[15:8] ^ {a[16], 7'h35};
    endfunction

    always_ff @(posedge clk) if (mem_rd) mem_rdata <= pat(mem_addr);

    int busy_cnt = 0;
    always_ff @(posedge clk) begin
        if (wr_commit) begin busy <= 1'b1; busy_cnt <= BUSY_CYC; end
        else if (busy_cnt > 1) busy_cnt <= busy_cnt - 1;
        else begin busy <= 1'b0; busy_cnt <= 0; end
    end

    int checks = 0, errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard: kind 0 = read request, 1 = write byte, 2 = commit
    typedef struct { int kind; logic [16:0] addr; logic [7:0] data; string tag; } item_t;
    item_t exp_q[$];

    task automatic push(input int kind, input logic [16:0] addr, input logic [7:0] data, input string tag);
        item_t it;
        it.kind = kind; it.addr = addr; it.data = data; it.tag = tag;
        exp_q.push_back(it);
    endtask

    always @(negedge clk) begin
        if (rst_n && (mem_rd || wr_en || wr_commit)) begin
            int kind;
            logic [16:0] a;
            logic [7:0] d;
            kind = mem_rd ? 0 : (wr_en ? 1 : 2);
            a = mem_rd ? mem_addr : (wr_en ? wr_addr : 17'h0);
            d = wr_en ? wr_data : 8'h0;
            if (exp_q.size() == 0) begin
                chk(0, "R10 unexpected strobe", kind, -1);
            end else begin
                item_t e;
                e = exp_q.pop_front();
                chk(kind == e.kind, {e.tag, " kind"}, kind, e.kind);
                chk(a == e.addr, {e.tag, " addr"}, int'(a), int'(e.addr));
                if (kind == 1) chk(d == e.data, {e.tag, " data"}, d, e.data);
            end
        end
    end

    task automatic wq; repeat (Q) @(posedge clk); #1; endtask

    task automatic m_start;
        sda_m = 1; wq; scl_m = 1; wq; sda_m = 0; wq; scl_m = 0; wq;
    endtask

    task automatic m_stop;
        sda_m = 0; wq; scl_m = 1; wq; sda_m = 1; wq;
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; wq; scl_m = 1; wq; wq; scl_m = 0; wq;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        send_bits(b, 8);
        sda_m = 1; wq; scl_m = 1; wq;
        acked = (sda_line == 1'b0);
        wq; scl_m = 0; wq;
    endtask

    task automatic read_byte(input bit mack, output logic [7:0] d);
        sda_m = 1;
        for (int i = 7; i >= 0; i--) begin
            wq; scl_m = 1; wq; d[i] = sda_line; wq; scl_m = 0;
        end
        wq; sda_m = mack ? 1'b0 : 1'b1; wq; scl_m = 1; wq; wq; scl_m = 0; wq; sda_m = 1;
    endtask

    task automatic exp_ack(input logic [7:0] b, input bit want, input string tag);
        bit a;
        send_byte(b, a);
        chk(a == want, tag, a, want);
    endtask

    task automatic exp_read(input bit mack, input logic [7:0] want, input string tag);
        logic [7:0] d;
        read_byte(mack, d);
        chk(d == want, tag, d, want);
    endtask

    task automatic wait_idle;
        wq;
        while (busy) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1;
        wq;
        chk(sda_oe == 0, "R11 sda released after reset", sda_oe, 0);

        // R1 R2 R3 R10: byte write to 0x12345
        push(1, 17'h12345, 8'hA5, "R3 byte write");
        push(2, 17'h0, 8'h0, "R10 commit");
        m_start;
        exp_ack(8'hAA, 1, "R1 device word ack");
        exp_ack(8'h23, 1, "R2 high address ack");
        exp_ack(8'h45, 1, "R2 low address ack");
        exp_ack(8'hA5, 1, "R2 data ack");
        m_stop;

        // R9: polling while busy, then after
        wq;
        chk(busy == 1, "R9 busy raised by commit", busy, 1);
        m_start;
        exp_ack(8'hAA, 0, "R9 no ack while busy");
        m_stop;
        wait_idle;
        m_start;
        exp_ack(8'hAA, 1, "R9 ack after busy");
        m_stop;

        // R7: current read, address bit in read word ignored
        push(0, 17'h12346, 8'h0, "R7 current read");
        m_start;
        exp_ack(8'hA9, 1, "R1 read word ack");
        exp_read(0, pat(17'h12346), "R4 read data");
        m_stop;

        // R1: mismatches
        m_start;
        exp_ack(8'hBA, 0, "R1 wrong code no ack");
        exp_ack(8'h00, 0, "R1 later byte ignored");
        m_stop;
        m_start;
        exp_ack(8'hA6, 0, "R1 wrong select no ack");
        m_stop;

        // R3: page wrap
        push(1, 17'h000FE, 8'h11, "R3 page byte0");
        push(1, 17'h000FF, 8'h22, "R3 page byte1");
        push(1, 17'h00000, 8'h33, "R3 page wrap");
        push(2, 17'h0, 8'h0, "R10 page commit");
        m_start;
        exp_ack(8'hA8, 1, "R2 header ack");
        exp_ack(8'h00, 1, "R2 high address ack");
        exp_ack(8'hFE, 1, "R2 low address ack");
        exp_ack(8'h11, 1, "R2 data ack");
        exp_ack(8'h22, 1, "R2 data ack");
        exp_ack(8'h33, 1, "R2 data ack");
        m_stop;
        wait_idle;
        push(0, 17'h00001, 8'h0, "R7 pointer after page write");
        m_start;
        exp_ack(8'hA9, 1, "R1 read word ack");
        exp_read(0, pat(17'h00001), "R7 read after wrap");
        m_stop;

        // R5 R6 R8: random read across top of array
        push(0, 17'h1FFFE, 8'h0, "R8 random read");
        push(0, 17'h1FFFF, 8'h0, "R5 sequential");
        push(0, 17'h00000, 8'h0, "R5 array wrap");
        m_start;
        exp_ack(8'hAA, 1, "R8 dummy header ack");
        exp_ack(8'hFF, 1, "R8 high address ack");
        exp_ack(8'hFE, 1, "R8 low address ack");
        m_start;
        exp_ack(8'hA9, 1, "R8 read word ack");
        exp_read(1, pat(17'h1FFFE), "R8 first byte");
        exp_read(1, pat(17'h1FFFF), "R5 second byte");
        exp_read(0, pat(17'h00000), "R5 wrapped byte");
        exp_read(0, 8'hFF, "R6 released after nack");
        m_stop;

        // R10: abort by start mid-byte, pointer untouched
        m_start;
        exp_ack(8'hA8, 1, "R2 header ack");
        send_bits(8'h10, 4);
        m_start;
        push(0, 17'h00001, 8'h0, "R10 start abort keeps pointer");
        exp_ack(8'hA9, 1, "R1 read word ack");
        exp_read(0, pat(17'h00001), "R10 read after abort");
        m_stop;

        // R10: stop mid-byte with no data gives no commit
        m_start;
        exp_ack(8'hA8, 1, "R2 header ack");
        send_bits(8'h00, 3);
        m_stop;

        // R10: a stop in mid-byte after one data byte commits that byte only
        push(1, 17'h00010, 8'h77, "R3 byte before abort");
        push(2, 17'h0, 8'h0, "R10 commit after partial");
        m_start;
        exp_ack(8'hA8, 1, "R2 header ack");
        exp_ack(8'h00, 1, "R2 high address ack");
        exp_ack(8'h10, 1, "R2 low address ack");
        exp_ack(8'h77, 1, "R2 data ack");
        send_bits(8'hC3, 5);
        m_stop;
        wait_idle;
        wq;

        chk(exp_q.size() == 0, "R10 all expected strobes seen", exp_q.size(), 0);
        chk(sda_oe == 0, "R6 released at end", sda_oe, 0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule